// File: doc/BRIEF.md
# Interrupt Status and Clear Controller

This block collects sixteen interrupt sources into one 16-bit status word that a processor reads over a small register bus. Sources are either level-following, where a bit mirrors its pin, or latched, where a bit stays set after its event until software writes that bit's end-of-interrupt location. Each source drives one of two outputs: a fast interrupt line for bits 3..0 and a normal interrupt line for bits 15..4.

Two inputs are noisy board pins: the battery-low condition and the media-change pin. Each passes through a deglitch filter clocked by a slow sampling enable, which is divided down from the system clock. The timer-1 underflow event is aligned to the timer's own clock. The battery-low and tick-watchdog sources are blanked while the chip is in a low-power state.

Top module: `irq_stat_ctrl`

## Requirements
- R1: A read with `bus_sel_i`=1, `bus_we_i`=0 and `bus_addr_i`=0 returns the status word in bits 15..0 and zero in bits 31..16. A read of any other address returns zero. A write to address 0 has no effect.
- R2: Status bit 0 is 1 exactly while `fast_pin_ni` is low, and it drives `fiq_o`.
- R3: Bits 5 and 6 are 1 while `ext1_ni` or `ext2_ni` (respectively) is low. Bit 7 is 1 while `ext3_i` is high. All three follow their pins with no latching and drive `irq_o`.
- R4: Bit 1 (battery low) is set when the filtered condition (`ext_pwr_ni` high and `batt_ok_i` low) is true. It stays set after the condition ends, until a write to address 17.
- R5: The battery condition and `media_pin_i` change their filtered value only after two consecutive slow-enable samples agree. A pulse shorter than one slow period (`DIV` system cycles) sets no bit.
- R6: Bit 3 (media change) is set on a rising edge of the filtered media pin. It stays set until a write to address 19.
- R7: Bit 11 (tick) is set by a pulse on `evt_upper_i[11]`. If a tick pulse arrives while bit 11 is still set, bit 2 (watchdog) is set. A write to address 27 clears both bit 11 and bit 2.
- R8: After a pulse on `tmr1_uf_i`, bit 8 is set on the first falling edge of `tmr1_clk_i` that follows. A write to address 24 clears it.
- R9: Bit 4 latches a `codec_thr_i` pulse. Bits 15..9 latch pulses on `evt_upper_i` (the same bit index). Each latched bit b clears on a write to address 16+b.
- R10: While `low_power_i` is 1, bits 1 and 2 are cleared on the next cycle and cannot be set.
- R11: `fiq_o` is the OR of status bits 3..0. `irq_o` is the OR of status bits 15..4.
- R12: A set event in the same cycle as its clear write leaves the bit set. Writes to the end-of-interrupt addresses of level bits 0, 5, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_pin_ni | input | 1 | External fast interrupt pin, active low |
| ext_pwr_ni | input | 1 | External power present, active low |
| batt_ok_i | input | 1 | Battery OK, high when good |
| media_pin_i | input | 1 | Media-change pin; rising edge is the event |
| ext1_ni | input | 1 | External interrupt 1, active low |
| ext2_ni | input | 1 | External interrupt 2, active low |
| ext3_i | input | 1 | External interrupt 3 request, active high |
| low_power_i | input | 1 | Low-power state indicator |
| codec_thr_i | input | 1 | Codec FIFO threshold event pulse |
| tmr1_uf_i | input | 1 | Timer-1 underflow pulse |
| tmr1_clk_i | input | 1 | Timer-1 clock level, synchronous to clk_i |
| evt_upper_i | input | 7 | Event pulses for status bits 15..9 (bit 11 is the tick) |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Bus write enable |
| bus_addr_i | input | ADDR_W | Word address |
| bus_rdata_o | output | DW | Read data |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The assertions check on every cycle four things:
- latched bits hold until their clear and a set beats a clear;
- the filtered pins change only on a slow-enable sample that agrees with the previous one;
- low power blanks bits 1 and 2, and the watchdog and timer-1 bits rise only on their qualifying events;
- a low fast pin always drives `fiq_o`.

Only the bench scenarios can show the rest. These are the address map of the bus, and the rejection of glitches shorter than a slow period. They also cover the second-tick condition for the watchdog and the alignment of the underflow to the next timer falling edge. Finally, they show that end-of-interrupt writes to level bits change nothing.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 16;
  localparam int EOI_BASE = 16;

  localparam int B_FASTPIN = 0;
  localparam int B_BATLOW  = 1;
  localparam int B_WDOG    = 2;
  localparam int B_MEDIA   = 3;
  localparam int B_CODEC   = 4;
  localparam int B_EXT1    = 5;
  localparam int B_EXT2    = 6;
  localparam int B_EXT3    = 7;
  localparam int B_TMR1    = 8;
  localparam int B_TICK    = 11;

  // 1 = latched until end-of-interrupt write, 0 = follows its source level
  localparam logic [NSRC-1:0] LATCH_MASK = 16'hFF1E;
endpackage

// File: rtl/irq_slow_en.sv
module irq_slow_en #(
  parameter int DIV = 6250
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic en_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign en_o = (cnt_q == LAST);
endmodule

// File: rtl/irq_deglitch.sv
module irq_deglitch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic smp_q, q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= RST_VAL;
      q_q   <= RST_VAL;
    end else if (en_i) begin
      smp_q <= d_i;
      if (d_i == smp_q) q_q <= d_i;
    end
  end

  assign q_o = q_q;

  // R5: output moves only on a slow sample that agrees with the previous one
  a_r5_hold_between_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_q));
  a_r5_needs_agreement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (d_i != smp_q)) |=> $stable(q_q));
endmodule

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (MASK[g]) begin : g_latch
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q_q <= 1'b0;
        else if (set_i[g]) q_q <= 1'b1;  // set beats clear
        else if (clr_i[g]) q_q <= 1'b0;
      end
      assign q_o[g] = q_q;

      a_r9_hold_until_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_q && !clr_i[g]) |=> q_q);
      a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[g] |=> q_q);
      a_r9_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[g] && !set_i[g]) |=> !q_q);
    end else begin : g_level
      assign q_o[g] = set_i[g];
    end
  end
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_pkg::*;
#(
  parameter int DIV    = 6250,
  parameter int ADDR_W = 5,
  parameter int DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_pin_ni,
  input  logic              ext_pwr_ni,
  input  logic              batt_ok_i,
  input  logic              media_pin_i,
  input  logic              ext1_ni,
  input  logic              ext2_ni,
  input  logic              ext3_i,
  input  logic              low_power_i,
  input  logic              codec_thr_i,
  input  logic              tmr1_uf_i,
  input  logic              tmr1_clk_i,
  input  logic [15:9]       evt_upper_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  logic            slow_en;
  logic            bat_flt, media_flt, media_flt_q;
  logic            tclk_q, tmr_pend_q, tmr_fall;
  logic [NSRC-1:0] stat, set_v, clr_v, eoi;
  logic            wr_hit, rd_hit;

  irq_slow_en #(.DIV(DIV)) u_slow (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_o(slow_en)
  );

  irq_deglitch #(.RST_VAL(1'b0)) u_flt_bat (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(slow_en),
    .d_i(ext_pwr_ni & ~batt_ok_i), .q_o(bat_flt)
  );

  irq_deglitch #(.RST_VAL(1'b0)) u_flt_media (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(slow_en),
    .d_i(media_pin_i), .q_o(media_flt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      media_flt_q <= 1'b0;
      tclk_q      <= 1'b0;
      tmr_pend_q  <= 1'b0;
    end else begin
      media_flt_q <= media_flt;
      tclk_q      <= tmr1_clk_i;
      tmr_pend_q  <= tmr1_uf_i | (tmr_pend_q & ~tmr_fall);
    end
  end

  assign tmr_fall = tclk_q & ~tmr1_clk_i;

  assign wr_hit = bus_sel_i & bus_we_i;
  assign rd_hit = bus_sel_i & ~bus_we_i;

  for (genvar b = 0; b < NSRC; b++) begin : g_eoi
    assign eoi[b] = wr_hit && (bus_addr_i == ADDR_W'(EOI_BASE + b));
  end

  always_comb begin
    set_v              = '0;
    set_v[B_FASTPIN]   = ~fast_pin_ni;
    set_v[B_BATLOW]    = bat_flt & ~low_power_i;
    set_v[B_WDOG]      = evt_upper_i[B_TICK] & stat[B_TICK] & ~low_power_i;
    set_v[B_MEDIA]     = media_flt & ~media_flt_q;
    set_v[B_CODEC]     = codec_thr_i;
    set_v[B_EXT1]      = ~ext1_ni;
    set_v[B_EXT2]      = ~ext2_ni;
    set_v[B_EXT3]      = ext3_i;
    set_v[15:9]        = evt_upper_i;
    set_v[B_TMR1]      = tmr_pend_q & tmr_fall;

    clr_v              = eoi;
    clr_v[B_BATLOW]    = eoi[B_BATLOW] | low_power_i;
    clr_v[B_WDOG]      = eoi[B_WDOG] | eoi[B_TICK] | low_power_i;
  end

  irq_evt_latch #(.W(NSRC), .MASK(LATCH_MASK)) u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v), .clr_i(clr_v), .q_o(stat)
  );

  assign bus_rdata_o = (rd_hit && bus_addr_i == '0) ? DW'(stat) : '0;
  assign fiq_o       = |stat[3:0];
  assign irq_o       = |stat[NSRC-1:4];

  a_r2_pin_to_fiq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_pin_ni |-> fiq_o);
  a_r10_lowpower_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_power_i |=> (!stat[B_BATLOW] && !stat[B_WDOG]));
  a_r7_wdog_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat[B_WDOG] && !evt_upper_i[B_TICK]) |=> !stat[B_WDOG]);
  a_r8_tmr_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat[B_TMR1] && !(tclk_q && !tmr1_clk_i)) |=> !stat[B_TMR1]);
endmodule

// File: tb/irq_stat_ctrl_test.sv
module irq_stat_ctrl_test;
  localparam int DIV = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fast_pin_n = 1, ext_pwr_n = 0, batt_ok = 1, media = 0;
  logic        ext1_n = 1, ext2_n = 1, ext3 = 0, low_power = 0;
  logic        codec = 0, tmr_uf = 0, tmr_clk = 1;
  logic [15:9] evt = '0;
  logic        sel = 0, we = 0;
  logic [4:0]  addr = '0;
  logic [31:0] rdata;
  logic        fiq, irq;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_stat_ctrl #(.DIV(DIV), .ADDR_W(5), .DW(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fast_pin_ni(fast_pin_n), .ext_pwr_ni(ext_pwr_n),
    .batt_ok_i(batt_ok), .media_pin_i(media), .ext1_ni(ext1_n), .ext2_ni(ext2_n),
    .ext3_i(ext3), .low_power_i(low_power), .codec_thr_i(codec), .tmr1_uf_i(tmr_uf),
    .tmr1_clk_i(tmr_clk), .evt_upper_i(evt), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    #1 v = rdata;
    sel = 0; addr = '0;
  endtask

  task automatic eoi(int b);
    @(negedge clk);
    sel = 1; we = 1; addr = 5'(16 + b);
    @(negedge clk);
    sel = 0; we = 0; addr = '0;
  endtask

  task automatic tick();
    @(negedge clk); evt[11] = 1;
    @(negedge clk); evt[11] = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v);
    chk("R1 reset status", v, 32'h0);
    chk("R11 reset outputs", {30'h0, fiq, irq}, 32'h0);
  endtask

  task automatic t_addr_map();
    logic [31:0] v;
    fast_pin_n = 0; ext3 = 1;
    rd(0, v); chk("R1 status upper zero", v, 32'h0000_0081);
    rd(3, v); chk("R1 other address reads zero", v, 32'h0);
    @(negedge clk); sel = 1; we = 1; addr = 0;
    @(negedge clk); sel = 0; we = 0;
    rd(0, v); chk("R1 write to status ignored", v, 32'h0000_0081);
    fast_pin_n = 1; ext3 = 0;
  endtask

  task automatic t_fast_pin();
    logic [31:0] v;
    fast_pin_n = 0;
    rd(0, v); chk("R2 pin low sets bit0", v, 32'h1);
    chk("R2 R11 fiq high irq low", {30'h0, fiq, irq}, 32'h2);
    fast_pin_n = 1;
    rd(0, v); chk("R2 pin high clears bit0", v, 32'h0);
  endtask

  task automatic t_ext();
    logic [31:0] v;
    ext1_n = 0;
    rd(0, v); chk("R3 ext1 low", v, 32'h20);
    chk("R3 R11 irq from ext1", {30'h0, fiq, irq}, 32'h1);
    ext1_n = 1; ext2_n = 0;
    rd(0, v); chk("R3 ext2 low, ext1 released", v, 32'h40);
    ext2_n = 1; ext3 = 1;
    rd(0, v); chk("R3 ext3 high", v, 32'h80);
    ext3 = 0;
    rd(0, v); chk("R3 all released", v, 32'h0);
  endtask

  task automatic t_batt();
    logic [31:0] v;
    ext_pwr_n = 1; batt_ok = 0;
    cyc(4 * DIV);
    rd(0, v); chk("R4 battery low latched", v, 32'h2);
    chk("R11 fiq from battery", {31'h0, fiq}, 32'h1);
    ext_pwr_n = 0; batt_ok = 1;
    cyc(4 * DIV);
    rd(0, v); chk("R4 stays after condition ends", v, 32'h2);
    eoi(1);
    rd(0, v); chk("R4 cleared by eoi 17", v, 32'h0);
  endtask

  task automatic t_glitch();
    logic [31:0] v;
    ext_pwr_n = 1; batt_ok = 0;
    cyc(DIV / 2);
    ext_pwr_n = 0; batt_ok = 1;
    cyc(4 * DIV);
    rd(0, v); chk("R5 short battery glitch rejected", v, 32'h0);
    media = 1;
    cyc(DIV / 2 - 1);
    media = 0;
    cyc(4 * DIV);
    rd(0, v); chk("R5 short media glitch rejected", v, 32'h0);
  endtask

  task automatic t_media();
    logic [31:0] v;
    media = 1;
    cyc(4 * DIV);
    rd(0, v); chk("R6 media rise sets bit3", v, 32'h8);
    media = 0;
    cyc(4 * DIV);
    rd(0, v); chk("R6 media stays latched", v, 32'h8);
    eoi(3);
    rd(0, v); chk("R6 cleared by eoi 19", v, 32'h0);
  endtask

  task automatic t_wdog();
    logic [31:0] v;
    tick();
    rd(0, v); chk("R7 first tick", v, 32'h800);
    tick();
    rd(0, v); chk("R7 unserviced tick sets watchdog", v, 32'h804);
    chk("R11 both outputs", {30'h0, fiq, irq}, 32'h3);
    eoi(11);
    rd(0, v); chk("R7 eoi 27 clears tick and watchdog", v, 32'h0);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    tmr_clk = 1;
    @(negedge clk); tmr_uf = 1;
    @(negedge clk); tmr_uf = 0;
    cyc(2);
    rd(0, v); chk("R8 no set before timer falling edge", v, 32'h0);
    tmr_clk = 0;
    rd(0, v); chk("R8 set on timer falling edge", v, 32'h100);
    tmr_clk = 1;
    cyc(2);
    tmr_clk = 0;
    cyc(2);
    eoi(8);
    rd(0, v); chk("R8 cleared by eoi 24, no re-set", v, 32'h0);
    tmr_clk = 1;
  endtask

  task automatic t_codec_upper();
    logic [31:0] v;
    @(negedge clk); codec = 1;
    @(negedge clk); codec = 0;
    rd(0, v); chk("R9 codec latched", v, 32'h10);
    chk("R11 codec on irq only", {30'h0, fiq, irq}, 32'h1);
    @(negedge clk); evt = 7'b1000001;
    @(negedge clk); evt = '0;
    rd(0, v); chk("R9 upper events latched", v, 32'h8210);
    eoi(15);
    rd(0, v); chk("R9 eoi 31 clears bit15 only", v, 32'h0210);
    eoi(4); eoi(9);
    rd(0, v); chk("R9 remaining cleared", v, 32'h0);
  endtask

  task automatic t_lowpower();
    logic [31:0] v;
    ext_pwr_n = 1; batt_ok = 0;
    cyc(4 * DIV);
    rd(0, v); chk("R10 battery bit before low power", v, 32'h2);
    @(negedge clk); low_power = 1;
    rd(0, v); chk("R10 battery blanked in low power", v, 32'h0);
    tick(); tick();
    rd(0, v); chk("R10 watchdog blocked in low power", v, 32'h800);
    ext_pwr_n = 0; batt_ok = 1;
    cyc(4 * DIV);
    @(negedge clk); low_power = 0;
    eoi(11);
    rd(0, v); chk("R10 clean after exit", v, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    @(negedge clk); codec = 1; sel = 1; we = 1; addr = 5'd20;
    @(negedge clk); codec = 0; sel = 0; we = 0; addr = '0;
    rd(0, v); chk("R12 set beats clear", v, 32'h10);
    eoi(4);
    ext1_n = 0;
    eoi(5);
    rd(0, v); chk("R12 eoi on level bit ignored", v, 32'h20);
    ext1_n = 1;
    rd(0, v); chk("R12 level bit follows release", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    t_reset();
    t_addr_map();
    t_fast_pin();
    t_ext();
    t_batt();
    t_glitch();
    t_media();
    t_wdog();
    t_timer();
    t_codec_upper();
    t_lowpower();
    t_set_wins();
    cyc(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule